// File: doc/BRIEF.md
# Segmented Lookahead Adder

This block is the final carry-propagate stage of a multiplier datapath. It takes the two vectors left over after partial-product reduction, plus a single carry-in bit, and returns their full-width sum and the carry leaving the top bit. It is purely combinational and has no clock, reset or state.

The word is split into equal groups (eight bits each by default). Each group forms per-bit generate and propagate terms and then computes all of its internal carries as flattened two-level sum-of-products, so no carry ripples inside a group. Between groups the carry does ripple: the carry leaving one group is the carry entering the next group up. A build-time mode can instead duplicate every group above the lowest. Each duplicated group computes its result once for an incoming carry of zero and once for one, and a multiplexer picks the correct copy when the real carry arrives. The two modes must give the same result for every input.

Top module: `seg_cla_adder`

## Requirements
- R1: The `sum_o` port equals the low 32 bits of `a_in + b_in + c_in`, all taken as unsigned numbers.
- R2: The `c_in` bit adds exactly one unit at bit position 0; with both operands zero, `sum_o` equals `c_in` and `c_out` is 0.
- R3: The carry entering each 8-bit group (bits 8, 16 and 24) equals the carry out of the exact addition of all the bits below it, including `c_in`.
- R4: The `c_out` port equals bit 32 of the 33-bit unsigned sum `a_in + b_in + c_in`.
- R5: The ripple mode (`MODE` = CHAIN_RIPPLE, value 0) and the carry-select mode (`MODE` = CHAIN_SELECT, value 1) give identical `{c_out, sum_o}` for every input.
- R6: A carry produced at the top bit of any group (bit 7, 15 or 23) lands in the lowest bit of the next group. For example, 0x000000FF + 1 gives 0x00000100.
- R7: The outputs follow any input change with no clock edge involved, because the block holds no state.
- R8: A carry that propagates across all 32 bits works correctly: 0xFFFFFFFF + 0 + 1 gives sum 0 and carry-out 1, and 0xAAAAAAAA + 0x55555555 + 1 gives the same result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 32 | First addend (sum vector from the reduction tree) |
| b_in | input | 32 | Second addend (carry vector from the reduction tree) |
| c_in | input | 1 | Carry into bit 0 |
| sum_o | output | 32 | Low 32 bits of the total |
| c_out | output | 1 | Carry out of bit 31 |

## Verification
The bench goes after carries that cross group boundaries. If the link between groups were wrong, 0x000000FF + 1 or 0x00FFFFFF + 1 would leave the upper group unchanged, and the result would come out 256 or more too small. The bench also targets full-word propagation: all ones plus a carry-in, and the alternating patterns whose sum is all ones. A group carry expression that drops its longest product term would return all ones with no carry-out instead of zero with a carry-out. Both modes are instantiated side by side and compared on every vector. A select multiplexer with its inputs swapped therefore shows up as a mismatch whenever a group's incoming carry is 1.

// File: rtl/seg_add_pkg.sv
package seg_add_pkg;

    // Build-time choice for how groups above the lowest receive their carry.
    typedef enum logic {
        CHAIN_RIPPLE = 1'b0,
        CHAIN_SELECT = 1'b1
    } chain_mode_e;

    localparam int unsigned DEF_ADD_W = 32;
    localparam int unsigned DEF_GRP_W = 8;

endpackage

// File: rtl/cla_group.sv
// One lookahead slice: every internal carry is a flat OR of product terms.
module cla_group #(
    parameter int unsigned GW = 8
) (
    input  logic [GW-1:0] a_i,
    input  logic [GW-1:0] b_i,
    input  logic          cin_i,
    output logic [GW-1:0] sum_o,
    output logic          cout_o
);

    logic [GW-1:0] gen_w;
    logic [GW-1:0] prop_w;
    logic [GW:0]   carry_w;

    always_comb begin
        logic term_p;
        logic acc;
        gen_w      = a_i & b_i;
        prop_w     = a_i ^ b_i;
        carry_w    = '0;
        carry_w[0] = cin_i;
        for (int i = 0; i < int'(GW); i++) begin
            acc    = 1'b0;
            term_p = 1'b1;
            for (int j = i; j >= 0; j--) begin
                acc    = acc | (term_p & gen_w[j]);
                term_p = term_p & prop_w[j];
            end
            carry_w[i+1] = acc | (term_p & cin_i);
        end
    end

    assign sum_o  = prop_w ^ carry_w[GW-1:0];
    assign cout_o = carry_w[GW];

endmodule

// File: rtl/cla_select_group.sv
// Speculative slice: results for both carry-in values, picked by the real carry.
module cla_select_group #(
    parameter int unsigned GW = 8
) (
    input  logic [GW-1:0] a_i,
    input  logic [GW-1:0] b_i,
    input  logic          cin_i,
    output logic [GW-1:0] sum_o,
    output logic          cout_o
);

    logic [GW-1:0] sum_zero, sum_one;
    logic          cout_zero, cout_one;

    cla_group #(.GW(GW)) u_spec0 (
        .a_i   (a_i),
        .b_i   (b_i),
        .cin_i (1'b0),
        .sum_o (sum_zero),
        .cout_o(cout_zero)
    );

    cla_group #(.GW(GW)) u_spec1 (
        .a_i   (a_i),
        .b_i   (b_i),
        .cin_i (1'b1),
        .sum_o (sum_one),
        .cout_o(cout_one)
    );

    assign sum_o  = cin_i ? sum_one  : sum_zero;
    assign cout_o = cin_i ? cout_one : cout_zero;

endmodule

// File: rtl/seg_cla_adder.sv
module seg_cla_adder
    import seg_add_pkg::*;
#(
    parameter int unsigned ADD_W = DEF_ADD_W,
    parameter int unsigned GRP_W = DEF_GRP_W,
    parameter chain_mode_e MODE  = CHAIN_RIPPLE
) (
    input  logic [31:0] a_in,
    input  logic [31:0] b_in,
    input  logic        c_in,
    output logic [31:0] sum_o,
    output logic        c_out
);

    localparam int unsigned NGRP = ADD_W / GRP_W;

    // grp_c[k] is the carry entering group k; grp_c[NGRP] leaves the word.
    logic [NGRP:0] grp_c;

    assign grp_c[0] = c_in;

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        if (k == 0 || MODE == CHAIN_RIPPLE) begin : g_plain
            cla_group #(.GW(GRP_W)) u_grp (
                .a_i   (a_in[k*GRP_W +: GRP_W]),
                .b_i   (b_in[k*GRP_W +: GRP_W]),
                .cin_i (grp_c[k]),
                .sum_o (sum_o[k*GRP_W +: GRP_W]),
                .cout_o(grp_c[k+1])
            );
        end else begin : g_sel
            cla_select_group #(.GW(GRP_W)) u_grp (
                .a_i   (a_in[k*GRP_W +: GRP_W]),
                .b_i   (b_in[k*GRP_W +: GRP_W]),
                .cin_i (grp_c[k]),
                .sum_o (sum_o[k*GRP_W +: GRP_W]),
                .cout_o(grp_c[k+1])
            );
        end
    end

    assign c_out = grp_c[NGRP];

endmodule

// File: rtl/seg_add_chk.sv
module seg_add_chk #(
    parameter int unsigned ADD_W = 32,
    parameter int unsigned GRP_W = 8,
    parameter int unsigned NGRP  = 4
) (
    input logic [ADD_W-1:0] a_in,
    input logic [ADD_W-1:0] b_in,
    input logic             c_in,
    input logic [ADD_W-1:0] sum_o,
    input logic             c_out,
    input logic [NGRP:0]    grp_c
);

    always_comb begin
        logic [ADD_W:0] ref_w;
        logic [ADD_W:0] mask_w;
        logic [ADD_W:0] part_w;
        ref_w = {1'b0, a_in} + {1'b0, b_in} + {{ADD_W{1'b0}}, c_in};
        if (!$isunknown({a_in, b_in, c_in, sum_o, c_out, grp_c})) begin
            assert_sum_R1: assert (sum_o == ref_w[ADD_W-1:0])
                else $error("R1 sum %h exp %h", sum_o, ref_w[ADD_W-1:0]);
            assert_cout_R4: assert (c_out == ref_w[ADD_W])
                else $error("R4 cout %b exp %b", c_out, ref_w[ADD_W]);
            assert_cin_R2: assert (!(a_in == '0 && b_in == '0) ||
                                   (sum_o == {{(ADD_W-1){1'b0}}, c_in} && !c_out))
                else $error("R2 carry-in weight wrong");
            for (int k = 1; k < int'(NGRP); k++) begin
                mask_w = ({{ADD_W{1'b0}}, 1'b1} << (k*GRP_W)) - 1'b1;
                part_w = ({1'b0, a_in} & mask_w) + ({1'b0, b_in} & mask_w)
                         + {{ADD_W{1'b0}}, c_in};
                assert_link_R3: assert (grp_c[k] == part_w[k*GRP_W])
                    else $error("R3 group %0d carry %b", k, grp_c[k]);
            end
        end
    end

endmodule

bind seg_cla_adder seg_add_chk #(
    .ADD_W(ADD_W),
    .GRP_W(GRP_W),
    .NGRP (NGRP)
) u_chk (
    .a_in (a_in),
    .b_in (b_in),
    .c_in (c_in),
    .sum_o(sum_o),
    .c_out(c_out),
    .grp_c(grp_c)
);

// File: tb/tb_seg_cla_adder.sv
module tb_seg_cla_adder;
    import seg_add_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [31:0] a, b;
    logic        ci;
    logic [31:0] s_r, s_s;
    logic        co_r, co_s;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    seg_cla_adder #(.MODE(CHAIN_RIPPLE)) dut (
        .a_in(a), .b_in(b), .c_in(ci), .sum_o(s_r), .c_out(co_r));

    seg_cla_adder #(.MODE(CHAIN_SELECT)) dut_cs (
        .a_in(a), .b_in(b), .c_in(ci), .sum_o(s_s), .c_out(co_s));

    // {a, b, cin, expected carry, expected sum}
    localparam int NV = 12;
    localparam logic [97:0] VEC [NV] = '{
        {32'h00000000, 32'h00000000, 1'b0, 1'b0, 32'h00000000},
        {32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b1, 32'h00000000},
        {32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b1, 32'h00000000},
        {32'hAAAAAAAA, 32'h55555555, 1'b0, 1'b0, 32'hFFFFFFFF},
        {32'hAAAAAAAA, 32'h55555555, 1'b1, 1'b1, 32'h00000000},
        {32'h000000FF, 32'h00000001, 1'b0, 1'b0, 32'h00000100},
        {32'h0000FFFF, 32'h00000000, 1'b1, 1'b0, 32'h00010000},
        {32'h00FFFFFF, 32'h00000001, 1'b0, 1'b0, 32'h01000000},
        {32'h80000000, 32'h80000000, 1'b0, 1'b1, 32'h00000000},
        {32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1, 32'hFFFFFFFF},
        {32'h12345678, 32'h87654321, 1'b0, 1'b0, 32'h99999999},
        {32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b0, 32'h80000000}
    };

    task automatic check(input string tag, input logic [32:0] exp);
        n_cmp++;
        if ({co_r, s_r} !== exp) begin
            n_bad++;
            $display("FAIL %s ripple a=%h b=%h ci=%b got %h exp %h",
                     tag, a, b, ci, {co_r, s_r}, exp);
        end
        n_cmp++;
        if ({co_s, s_s} !== {co_r, s_r}) begin
            n_bad++;
            $display("FAIL R5 select a=%h b=%h ci=%b got %h exp %h",
                     a, b, ci, {co_s, s_s}, {co_r, s_r});
        end
    endtask

    task automatic apply(input logic [31:0] av, input logic [31:0] bv, input logic cv);
        @(posedge clk);
        a  = av;
        b  = bv;
        ci = cv;
        @(negedge clk);
    endtask

    initial begin
        a = '0; b = '0; ci = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle", 33'h0);

        // R1 R4 R6 R8: table walk
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][97:66], VEC[i][65:34], VEC[i][33]);
            check("R1/R4/R6/R8 table", VEC[i][32:0]);
        end

        // R2: carry-in alone
        apply(32'h0, 32'h0, 1'b1);
        check("R2 cin only", 33'h1);

        // R6: carry out of each group top bit
        for (int k = 1; k < 4; k++) begin
            logic [31:0] lo;
            lo = (32'h1 << (8*k)) - 1;
            apply(lo, 32'h0, 1'b1);
            check("R6 boundary", {1'b0, lo + 32'h1});
        end

        // R7: input change reflected mid-cycle without any edge
        apply(32'h00000010, 32'h00000020, 1'b0);
        #1 b = 32'h00000001;
        #1;
        check("R7 no clock", 33'h000000011);

        // R1 R3 R4: random against behavioural 33-bit addition
        for (int i = 0; i < 300; i++) begin
            logic [31:0] ra, rb;
            logic rc;
            ra = $urandom;
            rb = $urandom;
            rc = 1'($urandom);
            apply(ra, rb, rc);
            check("R1/R3/R4 random", {1'b0, ra} + {1'b0, rb} + {32'h0, rc});
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired got running exp done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule